// File: doc/BRIEF.md
# SDRAM Read-Interrupt Command Scheduler

This block sequences commands for a single-data-rate SDRAM controller on a row that is already open. It takes read, write and precharge requests over a valid/ready handshake. For each one it drives the command pins, the bank and column, the auto-precharge flag, the data mask and the data-bus driver enable. It exists so that a later write or precharge can cut short a read burst that is still returning data. Before an interrupting write, it raises the data mask early enough to silence the memory's output buffers and then drops the mask on the write clock, so that the write data itself is not masked. A precharge that truncates a read is held until the read has produced exactly the number of data words the requester asked for. This accounts for the memory continuing to output data for CAS latency minus one clocks after the precharge.

CAS latency (2 or 3), burst length, an optional extra turnaround NOP before an interrupting write, and full-page operation are parameters. Every command is registered, so it reaches the pins on the clock after the request is accepted or released.

Top module: `rdcut_sched`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, the command pins show NOP, the data mask and the driver enable are low, and `req_ready` is high.
- R2: The command pins `sd_cmd` = {ras_n, cas_n, we_n} use these codes: NOP 3'b111, READ 3'b101, WRITE 3'b100, PRECHARGE 3'b010. Request codes are 0 for read, 1 for write and 2 for precharge. A request issued without delay shows its command, bank and column on the clock after the accepting edge.
- R3: Read requests presented on consecutive clocks are all accepted, with `req_ready` staying high, and they produce one READ per clock in request order.
- R4: Read data counts as due on a clock if that clock is no more than CL+BL-1 clocks after the last READ. A write that would otherwise land on a clock with read data due is preceded by 2+TURN_NOP NOP clocks with the data mask high, and is then issued. The controller never drives the bus on a clock on which the memory drives it.
- R5: On every WRITE clock the data mask is low, the driver enable is high and `sd_dq_out` equals the request's write data. On every other clock the driver enable is low.
- R6: A write requested when no read data is due is issued on the next clock, with no mask lead-in.
- R7: After a WRITE, the data mask stays high on the following NOP clocks, up to BL-1 of them. Any new command ends this early, and a READ is issued with the mask low.
- R8: This rule covers a precharge to the bank of the last READ, where that READ did not select auto-precharge. Let `req_keep` be k, the number of read words wanted (1..BL). The PRECHARGE appears k clocks after the READ, which is CL-1 clocks before the last wanted word at READ+CL+k-1. If it is requested later than that, it appears on the next clock.
- R9: With FULL_PAGE=0, a precharge to the bank of a READ that selected auto-precharge is held until CL+BL clocks after that READ.
- R10: A precharge to a bank other than that of the last READ is issued on the next clock.
- R11: While a write or a precharge is being held back, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock edge when high with req_valid |
| req_op | input | 2 | 0 read, 1 write, 2 precharge |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Column for read or write |
| req_autopre | input | 1 | Auto-precharge flag for read or write |
| req_keep | input | KEEP_W | Precharge only: read words wanted from the last burst |
| req_wdata | input | DATA_W | Write data word |
| sd_cmd | output | 3 | {ras_n, cas_n, we_n} command code |
| sd_bank | output | BANK_W | Bank address |
| sd_col | output | COL_W | Column address |
| sd_autopre | output | 1 | Auto-precharge address bit |
| sd_dqm | output | 1 | Data mask |
| sd_dq_oe | output | 1 | Controller data-bus driver enable |
| sd_dq_out | output | DATA_W | Data driven onto the bus |

## Verification
The assertions assume that request fields stay stable while `req_valid` is high until acceptance, and that `req_keep` lies between 1 and BL. They also assume that the addressed row is open, so that any burst timing follows from the READ alone. The stimulus keeps within these limits. It also inserts a long idle gap before every table scenario, so that the read-age tracker and the write-mask tail start from their settled values. A behavioural model of the memory's output drivers in the bench replays the commands and masks seen on the pins. From this replay it judges contention and the validity of each write.

// File: rtl/rdcut_pkg.sv
package rdcut_pkg;

   // Pin encoding {ras_n, cas_n, we_n}
   typedef enum logic [2:0] {
      CMD_PRE   = 3'b010,
      CMD_WRITE = 3'b100,
      CMD_READ  = 3'b101,
      CMD_NOP   = 3'b111
   } sd_cmd_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_PRE   = 2'd2,
      OP_RSVD  = 2'd3
   } req_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MASK,
      ST_PREW
   } sched_st_e;

endpackage

// File: rtl/rdcut_age_track.sv
// Tracks clocks elapsed since the last READ on the pins, and its bank and flag.
module rdcut_age_track #(
   parameter int CL     = 2,
   parameter int BL     = 4,
   parameter int BANK_W = 2,
   parameter int AGE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_read,
   input  logic [BANK_W-1:0] issue_bank,
   input  logic              issue_ap,
   output logic [AGE_W-1:0]  age_q,
   output logic [BANK_W-1:0] bank_q,
   output logic              ap_q,
   output logic              rd_busy
);
   localparam logic [AGE_W-1:0] AGE_SAT  = AGE_W'(CL + BL);
   localparam logic [AGE_W-1:0] BUSY_LIM = AGE_W'(CL + BL - 2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_q  <= AGE_SAT;
         bank_q <= '0;
         ap_q   <= 1'b0;
      end else if (issue_read) begin
         age_q  <= '0;
         bank_q <= issue_bank;
         ap_q   <= issue_ap;
      end else if (age_q != AGE_SAT) begin
         age_q  <= age_q + AGE_W'(1);
      end
   end

   // A command placed on the next clock would meet read data still due.
   assign rd_busy = (age_q <= BUSY_LIM);

endmodule

// File: rtl/rdcut_wtail.sv
// Masks the unused beats of a single-word write burst.
module rdcut_wtail #(
   parameter int BL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_write,
   input  logic issue_other,
   output logic tail_mask
);
   localparam int CW = (BL > 1) ? $clog2(BL) : 1;

   generate
      if (BL == 1) begin : g_none
         assign tail_mask = 1'b0;
      end else begin : g_cnt
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (issue_write)     cnt_q <= CW'(BL - 1);
            else if (issue_other)     cnt_q <= '0;
            else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
         end
         assign tail_mask = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/rdcut_pre_gate.sv
// Decides whether a precharge placed on the next clock meets the truncation rule.
module rdcut_pre_gate #(
   parameter int CL        = 2,
   parameter int BL        = 4,
   parameter int BANK_W    = 2,
   parameter int KEEP_W    = 3,
   parameter int AGE_W     = 4,
   parameter bit FULL_PAGE = 1'b0
) (
   input  logic [AGE_W-1:0]  age_q,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic              rd_ap,
   input  logic [BANK_W-1:0] pre_bank,
   input  logic [KEEP_W-1:0] keep,
   output logic              pre_ok
);
   localparam logic [AGE_W-1:0] DRAIN = AGE_W'(CL + BL);

   logic [AGE_W-1:0] keep_x;
   logic [AGE_W-1:0] need_same;
   logic [AGE_W-1:0] need;
   logic [AGE_W-1:0] age_next;
   logic             ap_block;

   assign keep_x    = {{(AGE_W-KEEP_W){1'b0}}, keep};
   assign ap_block  = rd_ap && (FULL_PAGE == 1'b0);
   // Last wanted word sits at READ+CL+keep-1; precharge goes CL-1 earlier.
   assign need_same = ap_block ? DRAIN : keep_x;
   assign need      = (pre_bank == rd_bank) ? need_same : '0;
   assign age_next  = age_q + AGE_W'(1);
   assign pre_ok    = (age_next >= need);

endmodule

// File: rtl/rdcut_sched.sv
module rdcut_sched
   import rdcut_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 9,
   parameter int CL        = 2,
   parameter int BL        = 4,
   parameter int TURN_NOP  = 0,
   parameter bit FULL_PAGE = 1'b0,
   parameter int KEEP_W    = $clog2(BL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_autopre,
   input  logic [KEEP_W-1:0] req_keep,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [2:0]        sd_cmd,
   output logic [BANK_W-1:0] sd_bank,
   output logic [COL_W-1:0]  sd_col,
   output logic              sd_autopre,
   output logic              sd_dqm,
   output logic              sd_dq_oe,
   output logic [DATA_W-1:0] sd_dq_out
);
   localparam int MASK_CYC = 2 + TURN_NOP;
   localparam int AGE_W    = $clog2(CL + BL + 2) + 1;
   localparam logic [1:0] MASK_LAST = 2'(MASK_CYC - 1);
   localparam logic [AGE_W-1:0] DUE_LIM = AGE_W'(CL + BL - 1);
   localparam logic [AGE_W-1:0] DRAIN   = AGE_W'(CL + BL);

   // Elaboration-time parameter checks
   if (CL != 2 && CL != 3) begin : g_bad_cl
      $error("rdcut_sched: CL must be 2 or 3");
   end
   if (BL != 1 && BL != 2 && BL != 4 && BL != 8) begin : g_bad_bl
      $error("rdcut_sched: BL must be 1, 2, 4 or 8");
   end
   if (TURN_NOP < 0 || TURN_NOP > 1) begin : g_bad_turn
      $error("rdcut_sched: TURN_NOP must be 0 or 1");
   end
   if (KEEP_W < $clog2(BL + 1)) begin : g_bad_keep
      $error("rdcut_sched: KEEP_W too narrow for BL");
   end

   sched_st_e         st_q, nx_st;
   logic [1:0]        cnt_q, nx_cnt;
   logic              cap;
   logic [BANK_W-1:0] pend_bank;
   logic [COL_W-1:0]  pend_col;
   logic              pend_ap;
   logic [KEEP_W-1:0] pend_keep;
   logic [DATA_W-1:0] pend_data;

   sd_cmd_e           nx_cmd;
   logic [BANK_W-1:0] nx_bank;
   logic [COL_W-1:0]  nx_col;
   logic              nx_ap;
   logic              nx_dqm;
   logic              nx_oe;
   logic [DATA_W-1:0] nx_dout;

   logic [AGE_W-1:0]  age_q;
   logic [BANK_W-1:0] rd_bank_q;
   logic              rd_ap_q;
   logic              rd_busy;
   logic              tail_mask;
   logic              pre_ok;
   logic [BANK_W-1:0] gate_bank;
   logic [KEEP_W-1:0] gate_keep;

   rdcut_age_track #(
      .CL(CL), .BL(BL), .BANK_W(BANK_W), .AGE_W(AGE_W)
   ) age_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_read (nx_cmd == CMD_READ),
      .issue_bank (nx_bank),
      .issue_ap   (nx_ap),
      .age_q      (age_q),
      .bank_q     (rd_bank_q),
      .ap_q       (rd_ap_q),
      .rd_busy    (rd_busy)
   );

   rdcut_wtail #(.BL(BL)) tail_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_write (nx_cmd == CMD_WRITE),
      .issue_other (nx_cmd != CMD_NOP && nx_cmd != CMD_WRITE),
      .tail_mask   (tail_mask)
   );

   assign gate_bank = (st_q == ST_PREW) ? pend_bank : req_bank;
   assign gate_keep = (st_q == ST_PREW) ? pend_keep : req_keep;

   rdcut_pre_gate #(
      .CL(CL), .BL(BL), .BANK_W(BANK_W), .KEEP_W(KEEP_W),
      .AGE_W(AGE_W), .FULL_PAGE(FULL_PAGE)
   ) gate_i (
      .age_q    (age_q),
      .rd_bank  (rd_bank_q),
      .rd_ap    (rd_ap_q),
      .pre_bank (gate_bank),
      .keep     (gate_keep),
      .pre_ok   (pre_ok)
   );

   assign req_ready = (st_q == ST_IDLE);

   // Next-clock command decision
   always_comb begin
      nx_st   = st_q;
      nx_cnt  = cnt_q;
      cap     = 1'b0;
      nx_cmd  = CMD_NOP;
      nx_bank = '0;
      nx_col  = '0;
      nx_ap   = 1'b0;
      nx_dqm  = tail_mask;
      nx_oe   = 1'b0;
      nx_dout = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               unique case (req_op_e'(req_op))
                  OP_READ: begin
                     nx_cmd  = CMD_READ;
                     nx_bank = req_bank;
                     nx_col  = req_col;
                     nx_ap   = req_autopre;
                     nx_dqm  = 1'b0;
                  end
                  OP_WRITE: begin
                     if (rd_busy) begin
                        cap    = 1'b1;
                        nx_st  = ST_MASK;
                        nx_cnt = MASK_LAST;
                        nx_dqm = 1'b1;
                     end else begin
                        nx_cmd  = CMD_WRITE;
                        nx_bank = req_bank;
                        nx_col  = req_col;
                        nx_ap   = req_autopre;
                        nx_dqm  = 1'b0;
                        nx_oe   = 1'b1;
                        nx_dout = req_wdata;
                     end
                  end
                  OP_PRE: begin
                     if (pre_ok) begin
                        nx_cmd  = CMD_PRE;
                        nx_bank = req_bank;
                     end else begin
                        cap   = 1'b1;
                        nx_st = ST_PREW;
                     end
                  end
                  default: ;
               endcase
            end
         end
         ST_MASK: begin
            if (cnt_q == 2'd0) begin
               nx_cmd  = CMD_WRITE;
               nx_bank = pend_bank;
               nx_col  = pend_col;
               nx_ap   = pend_ap;
               nx_dqm  = 1'b0;
               nx_oe   = 1'b1;
               nx_dout = pend_data;
               nx_st   = ST_IDLE;
            end else begin
               nx_dqm = 1'b1;
               nx_cnt = cnt_q - 2'd1;
            end
         end
         ST_PREW: begin
            if (pre_ok) begin
               nx_cmd  = CMD_PRE;
               nx_bank = pend_bank;
               nx_st   = ST_IDLE;
            end
         end
         default: nx_st = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= nx_st;
         cnt_q <= nx_cnt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_bank <= '0;
         pend_col  <= '0;
         pend_ap   <= 1'b0;
         pend_keep <= '0;
         pend_data <= '0;
      end else if (cap) begin
         pend_bank <= req_bank;
         pend_col  <= req_col;
         pend_ap   <= req_autopre;
         pend_keep <= req_keep;
         pend_data <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sd_cmd     <= CMD_NOP;
         sd_bank    <= '0;
         sd_col     <= '0;
         sd_autopre <= 1'b0;
         sd_dqm     <= 1'b0;
         sd_dq_oe   <= 1'b0;
         sd_dq_out  <= '0;
      end else begin
         sd_cmd     <= nx_cmd;
         sd_bank    <= nx_bank;
         sd_col     <= nx_col;
         sd_autopre <= nx_ap;
         sd_dqm     <= nx_dqm;
         sd_dq_oe   <= nx_oe;
         sd_dq_out  <= nx_dout;
      end
   end

   // ---------------- assertions ----------------
   // R3
   rd_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == OP_READ) |=> (sd_cmd == CMD_READ && req_ready));

   // R4
   wr_mask_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_WRITE && age_q <= DUE_LIM) |-> ($past(sd_dqm) && $past(sd_dqm, 2)));

   // R4
   wr_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == OP_WRITE && rd_busy) |=> (sd_cmd == CMD_NOP && sd_dqm));

   // R5
   wr_dqm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_WRITE) |-> (!sd_dqm && sd_dq_oe));

   // R5
   oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |-> (sd_cmd == CMD_WRITE));

   // R7
   tail_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sd_cmd) == CMD_WRITE && sd_cmd == CMD_NOP && BL > 1) |-> sd_dqm);

   // R9
   ap_pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_PRE && sd_bank == rd_bank_q && rd_ap_q && !FULL_PAGE) |-> (age_q >= DRAIN));

endmodule

// File: tb/rdcut_sched_tb_top.sv
module rdcut_sched_tb_top;
   import rdcut_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int T_CL = 2;
   localparam int T_BL = 4;
   localparam int DW = 16;
   localparam int BW = 2;
   localparam int CW = 9;
   localparam int KW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'd0;
   logic [BW-1:0] req_bank = '0;
   logic [CW-1:0] req_col = '0;
   logic          req_autopre = 1'b0;
   logic [KW-1:0] req_keep = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [2:0]    sd_cmd;
   logic [BW-1:0] sd_bank;
   logic [CW-1:0] sd_col;
   logic          sd_autopre;
   logic          sd_dqm;
   logic          sd_dq_oe;
   logic [DW-1:0] sd_dq_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   rdcut_sched #(
      .DATA_W(DW), .BANK_W(BW), .COL_W(CW), .CL(T_CL), .BL(T_BL),
      .TURN_NOP(0), .FULL_PAGE(1'b0), .KEEP_W(KW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_bank(req_bank), .req_col(req_col),
      .req_autopre(req_autopre), .req_keep(req_keep), .req_wdata(req_wdata),
      .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_col(sd_col),
      .sd_autopre(sd_autopre), .sd_dqm(sd_dqm), .sd_dq_oe(sd_dq_oe),
      .sd_dq_out(sd_dq_out)
   );

   int n_checks = 0;
   int n_errors = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Behavioural model of the memory's output drivers, replayed from the pins.
   int cyc = 0;
   int mem_from = 1 << 30;
   int mem_until = -1;
   int last_rd_bank = 0;
   bit d1 = 1'b0, d2 = 1'b0;
   int contention = 0;
   int bad_wr = 0;
   int oe_stray = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit due;
         due = (cyc >= mem_from) && (cyc <= mem_until);
         if (due && !d2 && sd_dq_oe) contention++;
         if (sd_cmd == CMD_WRITE && due && !(d1 && d2)) bad_wr++;
         if (sd_dq_oe && sd_cmd != CMD_WRITE) oe_stray++;
         if (sd_cmd == CMD_READ) begin
            mem_from     = cyc + T_CL;
            mem_until    = cyc + T_CL + T_BL - 1;
            last_rd_bank = int'(sd_bank);
         end else if (sd_cmd == CMD_WRITE) begin
            if (mem_until >= cyc) mem_until = cyc - 1;
         end else if (sd_cmd == CMD_PRE && int'(sd_bank) == last_rd_bank) begin
            if (mem_until > cyc + T_CL - 1) mem_until = cyc + T_CL - 1;
         end
         d2 = d1;
         d1 = sd_dqm;
         cyc++;
      end
   end

   // Called just after a falling edge; returns at the falling edge after acceptance.
   task automatic drive_req(input logic [1:0] op, input logic [BW-1:0] bank,
                            input logic [CW-1:0] col, input logic ap,
                            input logic [KW-1:0] keep, input logic [DW-1:0] wd);
      req_valid   = 1'b1;
      req_op      = op;
      req_bank    = bank;
      req_col     = col;
      req_autopre = ap;
      req_keep    = keep;
      req_wdata   = wd;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   typedef struct packed {
      logic          pre;   // issue a READ to bank 0 first
      logic          ap;    // auto-precharge on that READ
      logic [3:0]    gap;   // idle clocks between READ and the request
      logic [1:0]    op;
      logic [BW-1:0] bank;
      logic [KW-1:0] keep;
      logic [3:0]    exp;   // clocks from accepting edge to command
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 4'd0, 2'd1, 2'd0, 3'd0, 4'd1},  // R6 idle write
      '{1'b1, 1'b0, 4'd0, 2'd1, 2'd0, 3'd0, 4'd3},  // R4 write right after read
      '{1'b1, 1'b0, 4'd4, 2'd1, 2'd0, 3'd0, 4'd3},  // R4 last due clock
      '{1'b1, 1'b0, 4'd5, 2'd1, 2'd0, 3'd0, 4'd1},  // R6 just past due window
      '{1'b1, 1'b0, 4'd0, 2'd2, 2'd0, 3'd1, 4'd1},  // R8 keep 1
      '{1'b1, 1'b0, 4'd0, 2'd2, 2'd0, 3'd3, 4'd3},  // R8 keep 3
      '{1'b1, 1'b0, 4'd1, 2'd2, 2'd0, 3'd3, 4'd2},  // R8 keep 3, late request
      '{1'b1, 1'b0, 4'd0, 2'd2, 2'd0, 3'd4, 4'd4},  // R8 full burst
      '{1'b1, 1'b1, 4'd0, 2'd2, 2'd0, 3'd2, 4'd6},  // R9 auto-precharge read
      '{1'b1, 1'b1, 4'd0, 2'd2, 2'd1, 3'd2, 4'd1},  // R10 other bank
      '{1'b1, 1'b0, 4'd0, 2'd0, 2'd2, 3'd0, 4'd1},  // R2 read after read
      '{1'b1, 1'b1, 4'd2, 2'd1, 2'd0, 3'd0, 4'd3}   // R4 gap 2
   };

   function automatic string tag_of(input vec_t v);
      if (v.op == 2'd0) return "R2";
      if (v.op == 2'd1) return (v.exp > 4'd1) ? "R4" : "R6";
      if (v.bank != 2'd0) return "R10";
      if (v.ap) return "R9";
      return "R8";
   endfunction

   function automatic logic [2:0] cmd_of(input logic [1:0] op);
      case (op)
         2'd0:    return 3'b101;
         2'd1:    return 3'b100;
         default: return 3'b010;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      vec_t v;
      int n;
      bit all_dqm, rdy_low;
      logic [DW-1:0] wd;

      // R1 reset state
      repeat (3) @(negedge clk);
      check(sd_cmd == 3'b111, "R1", "cmd in reset", sd_cmd, 3'b111);
      check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(sd_cmd == 3'b111, "R1", "cmd after reset", sd_cmd, 3'b111);
      check(sd_dqm == 1'b0, "R1", "dqm after reset", sd_dqm, 0);
      check(sd_dq_oe == 1'b0, "R1", "oe after reset", sd_dq_oe, 0);
      check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

      // Table of scenarios
      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         repeat (12) @(negedge clk);
         if (v.pre) drive_req(2'd0, 2'd0, 9'd5, v.ap, 3'd0, 16'h0);
         repeat (int'(v.gap)) @(negedge clk);
         wd = 16'hA000 + 16'(i);
         drive_req(v.op, v.bank, 9'(i + 32), 1'b0, v.keep, wd);
         n = 1;
         all_dqm = 1'b1;
         rdy_low = 1'b1;
         while (sd_cmd == 3'b111 && n < 20) begin
            all_dqm &= sd_dqm;
            rdy_low &= !req_ready;
            @(negedge clk);
            n++;
         end
         check(n == int'(v.exp), tag_of(v), $sformatf("vector %0d delay", i), n, int'(v.exp));
         check(sd_cmd == cmd_of(v.op), "R2", $sformatf("vector %0d cmd", i),
               sd_cmd, cmd_of(v.op));
         check(sd_bank == v.bank, "R2", $sformatf("vector %0d bank", i), sd_bank, v.bank);
         if (v.op == 2'd1) begin
            check(!sd_dqm && sd_dq_oe, "R5", $sformatf("vector %0d dqm/oe", i),
                  {sd_dqm, sd_dq_oe}, 1);
            check(sd_dq_out == wd, "R5", $sformatf("vector %0d wdata", i), sd_dq_out, wd);
            if (v.exp > 4'd1)
               check(all_dqm, "R4", $sformatf("vector %0d mask lead-in", i), all_dqm, 1);
         end
         if (v.exp > 4'd1)
            check(rdy_low, "R11", $sformatf("vector %0d ready held", i), rdy_low, 1);
      end

      // R3 back-to-back reads
      repeat (12) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_bank = 2'd3; req_col = 9'd8;
      req_autopre = 1'b0;
      for (int i = 0; i < 4; i++) begin
         check(req_ready == 1'b1, "R3", $sformatf("ready before read %0d", i), req_ready, 1);
         @(negedge clk);
         check(sd_cmd == 3'b101 && sd_col == 9'(8 + i), "R3",
               $sformatf("read %0d column", i), sd_col, 8 + i);
         if (i < 3) req_col = 9'(9 + i);
         else req_valid = 1'b0;
      end

      // R7 write tail mask
      repeat (12) @(negedge clk);
      drive_req(2'd1, 2'd1, 9'd40, 1'b0, 3'd0, 16'h1234);
      check(sd_cmd == 3'b100, "R7", "tail test write", sd_cmd, 3'b100);
      for (int k = 1; k < T_BL; k++) begin
         @(negedge clk);
         check(sd_cmd == 3'b111 && sd_dqm, "R7", $sformatf("tail beat %0d masked", k), sd_dqm, 1);
      end
      @(negedge clk);
      check(sd_dqm == 1'b0, "R7", "tail ends", sd_dqm, 0);
      repeat (4) @(negedge clk);
      drive_req(2'd1, 2'd1, 9'd41, 1'b0, 3'd0, 16'h4321);
      drive_req(2'd0, 2'd1, 9'd42, 1'b0, 3'd0, 16'h0);
      check(sd_cmd == 3'b101 && sd_dqm == 1'b0, "R7", "read ends tail with mask low",
            sd_dqm, 0);

      repeat (12) @(negedge clk);
      check(contention == 0, "R4", "bus contention clocks", contention, 0);
      check(bad_wr == 0, "R4", "writes without mask lead-in", bad_wr, 0);
      check(oe_stray == 0, "R5", "driver enable off write clocks", oe_stray, 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule